// File: doc/BRIEF.md
# Pulse-Density Dithered Coarse DAC Driver

This block lets a 4-bit coarse DAC stand in for a 13-bit converter. It splits a 13-bit level into two parts. The upper four bits form a coarse DAC code. The lower nine bits form a fraction. On every dither step, the fraction is added to a 9-bit phase accumulator. When the addition carries out, the DAC is driven one code higher for that step. Otherwise it gets the coarse code. The carries fall evenly in time, not in one block as in a pulse-width scheme, so the analog low-pass filter that follows can be made faster for the same ripple.

A dither step is an enabled tick of the step source. Tie `tick_en_i` high to dither at the full clock rate. A slower strobe, a compile-time divider (`TICK_DIV`), or both give a lower dither rate. New levels come in on a valid/ready channel. The block never applies back-pressure outside reset, so `lvl_ready_o` drops only while `rst_i` is high. Any beat offered while ready is low is dropped. A newly accepted level is used from the next dither step onward. The accumulator phase carries on across the change.

Top module: `pdm_dither_dac`

## Requirements
- R1: While `rst_i` is high at a clock edge, the level register, the phase accumulator and the step divider are cleared and `dac_code_o` becomes 0.
- R2: An accepted level is split so that bits [12:9] are the coarse code and bits [8:0] are the fraction.
- R3: On each dither step, the accumulator becomes (accumulator + fraction) mod 512. `dac_code_o` then shows coarse+1 if that sum reached 512, or coarse if it did not. The new code is visible after the same clock edge, and the step uses the level accepted before that edge.
- R4: When the coarse code is 15 and a carry occurs, `dac_code_o` stays at 15 and does not wrap.
- R5: On a clock without a dither step, `dac_code_o` and the accumulator hold their values.
- R6: Over any 512 consecutive dither steps, exactly as many steps output coarse+1 as the 9-bit fraction value (coarse below 15).
- R7: Accepting a new level leaves the accumulator phase untouched.
- R8: `lvl_ready_o` is high exactly when `rst_i` is low. A beat is accepted when valid and ready are both high at a clock edge, and any other beat is ignored.
- R9: With `TICK_DIV` = N, a dither step happens on every Nth cycle with `tick_en_i` high, counting from reset. With N = 1, every such cycle is a step.
- R10: A fraction of 0 keeps `dac_code_o` at the coarse code on every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| lvl_valid_i | input | 1 | Level beat valid |
| lvl_ready_o | output | 1 | Level channel ready (low only in reset) |
| lvl_data_i | input | 13 | Level: coarse [12:9], fraction [8:0] |
| tick_en_i | input | 1 | Dither rate enable |
| dac_code_o | output | 4 | Code to the coarse DAC |

## Verification
A cycle-accurate behavioural model runs next to the design and is compared with it on every clock. Two instances are checked: one that steps on every enabled cycle and one that divides by three. The fractions tried are 0, 1, 255, 256, 511 and an odd value. Each runs for full 512-step windows, which separates an even pulse-density pattern with the correct count from one that is off by one or grouped into a block. A level of coarse 15 with a non-zero fraction shows whether the output saturates or wraps. Writing a new level halfway through an accumulation cycle shows whether the phase is kept or reset. Beats offered during reset, and steps held off with the enable low, show that those inputs are ignored.

// File: rtl/pdm_dac_pkg.sv
package pdm_dac_pkg;
  parameter int unsigned LEVEL_W_DEF  = 13;
  parameter int unsigned CODE_W_DEF   = 4;
  parameter int unsigned TICK_DIV_DEF = 1;
endpackage

// File: rtl/pdm_tick_div.sv
module pdm_tick_div #(
  parameter int unsigned DIV = 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_en_i,
  output logic step_o
);
  generate
    if (DIV <= 1) begin : g_direct
      assign step_o = tick_en_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      assign step_o = tick_en_i && (cnt_q == LAST);

      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          cnt_q <= '0;
        end else if (tick_en_i) begin
          cnt_q <= step_o ? '0 : cnt_q + 1'b1;
        end
      end

      // R9: a step only ever rides on an enabled tick
      p_step_on_tick_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        step_o |-> tick_en_i);
      // R9: with a divider above one, steps never fall on adjacent clocks
      p_step_gap_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        step_o |=> !step_o);
    end
  endgenerate
endmodule

// File: rtl/pdm_level_reg.sv
module pdm_level_reg #(
  parameter int unsigned LEVEL_W = 13,
  parameter int unsigned CODE_W  = 4,
  localparam int unsigned FRAC_W = LEVEL_W - CODE_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               valid_i,
  output logic               ready_o,
  input  logic [LEVEL_W-1:0] data_i,
  output logic [CODE_W-1:0]  coarse_o,
  output logic [FRAC_W-1:0]  frac_o
);
  logic [LEVEL_W-1:0] lvl_q;

  assign ready_o = !rst_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lvl_q <= '0;
    end else if (valid_i && ready_o) begin
      lvl_q <= data_i;
    end
  end

  assign coarse_o = lvl_q[LEVEL_W-1:FRAC_W];
  assign frac_o   = lvl_q[FRAC_W-1:0];

  // R8: an accepted beat is what the split fields show next cycle (R2)
  p_accept_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && ready_o) |=> ({coarse_o, frac_o} == $past(data_i)));
  // R8: with no beat offered the level stays put
  p_keep_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |=> $stable({coarse_o, frac_o}));
endmodule

// File: rtl/pdm_nco.sv
module pdm_nco #(
  parameter int unsigned FRAC_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q <= '0;
    end else if (step_i) begin
      acc_q <= sum[FRAC_W-1:0];
    end
  end

  // R5: phase frozen between steps (and so untouched by writes, R7)
  p_acc_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(acc_q));
  // R10: a zero fraction never moves the phase
  p_zero_frac_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && frac_i == '0) |-> !carry_o);
endmodule

// File: rtl/pdm_code_out.sv
module pdm_code_out #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              step_i,
  input  logic              carry_i,
  input  logic [CODE_W-1:0] coarse_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] TOP = '1;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      code_q <= '0;
    end else if (step_i) begin
      if (carry_i && coarse_i != TOP) code_q <= coarse_i + 1'b1;
      else                            code_q <= coarse_i;
    end
  end

  assign code_o = code_q;

  // R4: full-scale coarse with carry must stay at full scale
  p_sat_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && carry_i && coarse_i == TOP) |=> (code_o == TOP));
  // R5: no step, no change on the DAC code
  p_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(code_o));
  // R3: a step never lands below the coarse code
  p_floor_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    step_i |=> (code_o >= $past(coarse_i)));
endmodule

// File: rtl/pdm_dither_dac.sv
module pdm_dither_dac
  import pdm_dac_pkg::*;
#(
  parameter int unsigned LEVEL_W  = LEVEL_W_DEF,
  parameter int unsigned CODE_W   = CODE_W_DEF,
  parameter int unsigned TICK_DIV = TICK_DIV_DEF,
  localparam int unsigned FRAC_W  = LEVEL_W - CODE_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               lvl_valid_i,
  output logic               lvl_ready_o,
  input  logic [LEVEL_W-1:0] lvl_data_i,
  input  logic               tick_en_i,
  output logic [CODE_W-1:0]  dac_code_o
);
  logic              step;
  logic              carry;
  logic [CODE_W-1:0] coarse;
  logic [FRAC_W-1:0] frac;

  pdm_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk_i(clk_i), .rst_i(rst_i), .tick_en_i(tick_en_i), .step_o(step)
  );

  pdm_level_reg #(.LEVEL_W(LEVEL_W), .CODE_W(CODE_W)) u_lvl (
    .clk_i(clk_i), .rst_i(rst_i), .valid_i(lvl_valid_i), .ready_o(lvl_ready_o),
    .data_i(lvl_data_i), .coarse_o(coarse), .frac_o(frac)
  );

  pdm_nco #(.FRAC_W(FRAC_W)) u_nco (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(step), .frac_i(frac), .carry_o(carry)
  );

  pdm_code_out #(.CODE_W(CODE_W)) u_out (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(step), .carry_i(carry),
    .coarse_i(coarse), .code_o(dac_code_o)
  );

  // R1: one cycle after reset the DAC code reads zero
  p_reset_zero_r1: assert property (@(posedge clk_i)
    rst_i |=> (dac_code_o == '0));
endmodule

// File: tb/pdm_dither_dac_tb.sv
module pdm_dither_dac_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [12:0] din = '0;
  logic        ten = 1'b0;
  logic        rdy1, rdy3;
  logic [3:0]  code1, code3;

  int total = 0;
  int bad   = 0;

  // behavioural model state
  int mlvl = 0;
  int acc1 = 0, acc3 = 0, cnt3 = 0;
  int mc1 = 0, mc3 = 0;

  always #5 clk = ~clk;

  pdm_dither_dac u_dut (
    .clk_i(clk), .rst_i(rst), .lvl_valid_i(valid), .lvl_ready_o(rdy1),
    .lvl_data_i(din), .tick_en_i(ten), .dac_code_o(code1)
  );

  pdm_dither_dac #(.TICK_DIV(3)) u_div3 (
    .clk_i(clk), .rst_i(rst), .lvl_valid_i(valid), .lvl_ready_o(rdy3),
    .lvl_data_i(din), .tick_en_i(ten), .dac_code_o(code3)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_step(inout int acc, inout int code);
    int s;
    s = acc + (mlvl % 512);
    acc = s % 512;
    code = (mlvl / 512) + ((s >= 512) ? 1 : 0);
    if (code > 15) code = 15;
  endtask

  // one clock: model follows the edge, compare at the falling edge
  task automatic cycle();
    bit st3;
    @(posedge clk);
    if (rst) begin
      mlvl = 0; acc1 = 0; acc3 = 0; cnt3 = 0; mc1 = 0; mc3 = 0;
    end else begin
      st3 = 1'b0;
      if (ten) begin
        if (cnt3 == 2) begin st3 = 1'b1; cnt3 = 0; end
        else cnt3++;
      end
      if (ten) apply_step(acc1, mc1);
      if (st3) apply_step(acc3, mc3);
      if (valid) mlvl = int'(din);
    end
    @(negedge clk);
    check(code1 == 4'(mc1), "R3 code (div1)", int'(code1), mc1);
    check(code3 == 4'(mc3), "R9 code (div3)", int'(code3), mc3);
    check(rdy1 == !rst && rdy3 == !rst, "R8 ready", int'(rdy1), int'(!rst));
  endtask

  task automatic put(input int lvl);
    valid = 1'b1; din = 13'(lvl);
    cycle();
    valid = 1'b0;
  endtask

  task automatic density(input int coarse, input int frac);
    int hi;
    put(coarse * 512 + frac);
    ten = 1'b1;
    hi = 0;
    for (int i = 0; i < 512; i++) begin
      cycle();
      if (int'(code1) == coarse + 1) hi++;
    end
    ten = 1'b0;
    check(hi == frac, "R6 density count", hi, frac);
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 / R8: reset with a beat offered that must be dropped
    rst = 1'b1; valid = 1'b1; din = 13'h1FFF; ten = 1'b1;
    repeat (3) cycle();
    check(code1 == 0 && code3 == 0, "R1 reset code", int'(code1), 0);
    check(rdy1 == 1'b0, "R8 ready low in reset", int'(rdy1), 0);
    valid = 1'b0; rst = 1'b0;
    cycle();
    check(code1 == 0, "R8 reset-time beat ignored", int'(code1), 0);
    ten = 1'b0;

    // R7: phase survives a write (acc=256 then +256 must carry)
    put(2 * 512 + 256);
    ten = 1'b1; cycle(); ten = 1'b0;
    check(code1 == 2, "R7 first half", int'(code1), 2);
    put(5 * 512 + 256);
    ten = 1'b1; cycle(); ten = 1'b0;
    check(code1 == 6, "R7 carry after write", int'(code1), 6);

    // R2: field split, fraction zero shows coarse exactly
    put(9 * 512);
    ten = 1'b1; cycle();
    check(code1 == 9, "R2 coarse field", int'(code1), 9);
    // R10: zero fraction holds the coarse code across many steps
    for (int i = 0; i < 20; i++) begin
      cycle();
      check(code1 == 9, "R10 zero fraction", int'(code1), 9);
    end
    ten = 1'b0;

    // R5: no steps while beats arrive, code must not move
    begin
      logic [3:0] held;
      held = code1;
      put(3 * 512 + 511);
      put(12 * 512 + 7);
      repeat (4) cycle();
      check(code1 == held, "R5 hold without step", int'(code1), int'(held));
    end

    // R4: saturation at full scale
    put(15 * 512 + 300);
    ten = 1'b1;
    for (int i = 0; i < 40; i++) begin
      cycle();
      check(code1 == 15, "R4 saturate", int'(code1), 15);
    end
    ten = 1'b0;

    // R6: density windows
    density(7, 0);
    density(7, 1);
    density(7, 255);
    density(7, 256);
    density(7, 511);
    density(0, 137);

    // R9: irregular enable pattern for the divided instance
    put(4 * 512 + 171);
    for (int i = 0; i < 300; i++) begin
      ten = ((i % 5) != 1) && ((i % 7) != 3);
      cycle();
    end
    ten = 1'b0;
    cycle();

    // R1: reset mid-run clears everything
    ten = 1'b1; rst = 1'b1;
    cycle();
    check(code1 == 0 && code3 == 0, "R1 reset mid-run", int'(code1), 0);
    rst = 1'b0; ten = 1'b0;
    cycle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule